// File: doc/BRIEF.md
# Video Sync Shaper with Colour Priority

This block sits between a character-based display timing controller and the monitor. Each cycle it picks the colour sent to the screen by a fixed priority: black while either controller sync pulse is active, the border colour while the border signal is high, and the pixel colour otherwise. The pixel and border colours are inputs. Palette lookup and pixel fetch happen upstream.

It also re-times both sync pulses for the monitor. The monitor horizontal pulse starts a fixed number of characters after the controller horizontal pulse begins and has a fixed width. The monitor vertical pulse works the same way, but counts scanlines, one per falling edge of the controller horizontal pulse. If a controller pulse ends before its monitor window is over, the monitor pulse ends with it.

The block has two further outputs. An undelayed copy of the controller vertical pulse feeds a parallel-port status bit. A sync-active flag lets a later stage draw the sync level darker than palette black.

Top module: `video_sync_shaper`

## Requirements
- R1: While `ctl_hsync` or `ctl_vsync` is 1, `out_color` equals BLACK_CODE (default 0), regardless of `ctl_border` and both colour inputs.
- R2: While neither sync is active and `ctl_border` is 1, `out_color` equals `border_color`.
- R3: While neither sync is active and `ctl_border` is 0, `out_color` equals `pix_color`.
- R4: Characters of a controller horizontal pulse are numbered from 0. A character ends in a cycle with `char_en` high. With the defaults H_DELAY=2 and H_WIDTH=4, `mon_hsync` is 1 during characters 2 to 5 of a controller pulse that is at least 6 characters long. For example, a pulse starting at character 46 and lasting 14 characters gives monitor sync on characters 48 to 51.
- R5: When the controller horizontal pulse is shorter than H_DELAY+H_WIDTH characters, `mon_hsync` ends when the controller pulse ends. A 4-character pulse gives monitor sync on characters 2 and 3 only; a 2-character pulse gives none.
- R6: Each 1-to-0 transition of `ctl_hsync` while `ctl_vsync` is 1 counts one scanline. The count starts at 0 when `ctl_vsync` rises. With V_DELAY=2 and V_WIDTH=2, `mon_vsync` is 1 while the count is 2 or 3.
- R7: When `ctl_vsync` falls before the count reaches V_DELAY+V_WIDTH, `mon_vsync` ends at once. A pulse of 3 scanlines gives monitor sync only while the count is 2 or 3; a pulse of 1 scanline gives none.
- R8: `vsync_status` equals `ctl_vsync` in the same cycle, with no delay.
- R9: `sync_active` is 1 exactly when `ctl_hsync` or `ctl_vsync` is 1.
- R10: While `rst_n` is 0, `mon_hsync` and `mon_vsync` are 0 even if both controller syncs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_en | input | 1 | High in the last cycle of each character |
| ctl_hsync | input | 1 | Controller horizontal sync |
| ctl_vsync | input | 1 | Controller vertical sync |
| ctl_border | input | 1 | Controller border (display disabled) signal |
| pix_color | input | COLOR_W | Colour of the current pixel |
| border_color | input | COLOR_W | Border colour |
| out_color | output | COLOR_W | Colour sent to the display |
| mon_hsync | output | 1 | Re-timed monitor horizontal sync |
| mon_vsync | output | 1 | Re-timed monitor vertical sync |
| vsync_status | output | 1 | Undelayed controller vertical sync for a status port |
| sync_active | output | 1 | High while either controller sync is active |

## Verification
The bench uses the default parameters: a 6-bit colour, a horizontal delay of 2 and width of 4 characters, and a vertical delay and width of 2 scanlines each, with lines counted on the falling edge. The 6-character threshold therefore falls between the 4-character and 14-character test pulses, so one pulse shape exercises the full window and another exercises the cut-short case. The 2-character pulse never reaches the window at all. Vertical pulses of 6, 3 and 1 scanlines cover the full, cut and empty monitor windows, and the bench checks the colour output against the priority order in each of these states.

// File: rtl/vss_pkg.sv
package vss_pkg;

   typedef enum logic [1:0] {
      SRC_PIXEL  = 2'd0,
      SRC_BORDER = 2'd1,
      SRC_BLACK  = 2'd2
   } color_src_e;

   // Sync blanking outranks the border, which outranks the pixel.
   function automatic color_src_e pick_source(input logic hs, input logic vs, input logic brd);
      if (hs || vs)
         return SRC_BLACK;
      else if (brd)
         return SRC_BORDER;
      else
         return SRC_PIXEL;
   endfunction

endpackage

// File: rtl/sync_reshaper.sv
module sync_reshaper #(
   parameter int DELAY = 2,
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic pulse_in,
   output logic pulse_out
);
   localparam int LIMIT = DELAY + WIDTH;
   localparam int CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] D_C = CW'(DELAY);
   localparam logic [CW-1:0] L_C = CW'(LIMIT);

   if (WIDTH < 1) begin : g_bad_width
      $error("sync_reshaper: WIDTH must be at least 1");
   end
   if (DELAY < 0) begin : g_bad_delay
      $error("sync_reshaper: DELAY must not be negative");
   end

   logic [CW-1:0] cnt;

   // Counts completed steps inside the input pulse; saturates at the window end.
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!pulse_in)
         cnt <= '0;
      else if (step && (cnt != L_C))
         cnt <= cnt + 1'b1;
   end

   assign pulse_out = pulse_in && (cnt >= D_C) && (cnt < L_C);

   // Steps spent with the output high, tracked to bound the pulse width.
   logic [CW:0] on_steps;
   always_ff @(posedge clk) begin
      if (!rst_n || !pulse_out)
         on_steps <= '0;
      else if (step)
         on_steps <= on_steps + 1'b1;
   end

   AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      on_steps <= (CW+1)'(WIDTH)); // R4, R6

   if (DELAY > 0) begin : g_delay_chk
      AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pulse_in) |-> !pulse_out); // R4, R6
   end

endmodule

// File: rtl/color_priority.sv
module color_priority
   import vss_pkg::*;
#(
   parameter int COLOR_W    = 6,
   parameter int BLACK_CODE = 0
) (
   input  logic               hs,
   input  logic               vs,
   input  logic               brd,
   input  logic [COLOR_W-1:0] pix,
   input  logic [COLOR_W-1:0] bcol,
   output logic [COLOR_W-1:0] color,
   output logic               blank
);
   localparam logic [COLOR_W-1:0] BLACK_C = COLOR_W'(BLACK_CODE);

   color_src_e src;

   always_comb begin
      src = pick_source(hs, vs, brd);
      case (src)
         SRC_BLACK:  color = BLACK_C;
         SRC_BORDER: color = bcol;
         default:    color = pix;
      endcase
   end

   assign blank = (src == SRC_BLACK);

endmodule

// File: rtl/video_sync_shaper.sv
module video_sync_shaper #(
   parameter int COLOR_W      = 6,
   parameter int BLACK_CODE   = 0,
   parameter int H_DELAY      = 2,
   parameter int H_WIDTH      = 4,
   parameter int V_DELAY      = 2,
   parameter int V_WIDTH      = 2,
   parameter bit LINE_ON_FALL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               char_en,
   input  logic               ctl_hsync,
   input  logic               ctl_vsync,
   input  logic               ctl_border,
   input  logic [COLOR_W-1:0] pix_color,
   input  logic [COLOR_W-1:0] border_color,
   output logic [COLOR_W-1:0] out_color,
   output logic               mon_hsync,
   output logic               mon_vsync,
   output logic               vsync_status,
   output logic               sync_active
);
   localparam logic [COLOR_W-1:0] BLACK_C = COLOR_W'(BLACK_CODE);

   if (COLOR_W < 1) begin : g_bad_cw
      $error("video_sync_shaper: COLOR_W must be at least 1");
   end
   if (BLACK_CODE < 0 || BLACK_CODE >= (1 << COLOR_W)) begin : g_bad_black
      $error("video_sync_shaper: BLACK_CODE does not fit in COLOR_W bits");
   end

   // Scanline tick taken from an edge of the controller horizontal sync.
   logic hs_q;
   logic line_tick;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hs_q <= 1'b0;
      else
         hs_q <= ctl_hsync;
   end

   if (LINE_ON_FALL) begin : g_tick_fall
      assign line_tick = hs_q & ~ctl_hsync;
   end else begin : g_tick_rise
      assign line_tick = ~hs_q & ctl_hsync;
   end

   sync_reshaper #(.DELAY(H_DELAY), .WIDTH(H_WIDTH)) u_hshape (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (char_en),
      .pulse_in  (ctl_hsync),
      .pulse_out (mon_hsync)
   );

   sync_reshaper #(.DELAY(V_DELAY), .WIDTH(V_WIDTH)) u_vshape (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (line_tick),
      .pulse_in  (ctl_vsync),
      .pulse_out (mon_vsync)
   );

   color_priority #(.COLOR_W(COLOR_W), .BLACK_CODE(BLACK_CODE)) u_prio (
      .hs    (ctl_hsync),
      .vs    (ctl_vsync),
      .brd   (ctl_border),
      .pix   (pix_color),
      .bcol  (border_color),
      .color (out_color),
      .blank (sync_active)
   );

   assign vsync_status = ctl_vsync;

   AST_HS_FORCES_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      mon_hsync |-> (out_color == BLACK_C)); // R1

   AST_VS_FORCES_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      mon_vsync |-> (out_color == BLACK_C)); // R1

   if (V_DELAY > 0) begin : g_vs_align
      AST_VS_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mon_vsync) |-> $past(line_tick)); // R6
   end

endmodule

// File: tb/sim_video_sync_shaper.sv
`timescale 1ns/1ps
module sim_video_sync_shaper;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          char_en = 1'b0;
   logic          ctl_hsync = 1'b0;
   logic          ctl_vsync = 1'b0;
   logic          ctl_border = 1'b0;
   logic [CW-1:0] pix_color = '0;
   logic [CW-1:0] border_color = '0;
   logic [CW-1:0] out_color;
   logic          mon_hsync, mon_vsync, vsync_status, sync_active;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic          s_mh, s_mv, s_stat, s_sa;
   logic [CW-1:0] s_col;

   always #2.5 clk = ~clk;

   video_sync_shaper u0 (
      .clk(clk), .rst_n(rst_n), .char_en(char_en),
      .ctl_hsync(ctl_hsync), .ctl_vsync(ctl_vsync), .ctl_border(ctl_border),
      .pix_color(pix_color), .border_color(border_color),
      .out_color(out_color), .mon_hsync(mon_hsync), .mon_vsync(mon_vsync),
      .vsync_status(vsync_status), .sync_active(sync_active)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   // One character of three cycles; outputs sampled mid-character, char_en on the last.
   task automatic char_step(input logic h, input logic v, input logic b);
      @(negedge clk);
      ctl_hsync = h; ctl_vsync = v; ctl_border = b; char_en = 1'b0;
      @(negedge clk);
      s_mh = mon_hsync; s_mv = mon_vsync; s_col = out_color;
      s_stat = vsync_status; s_sa = sync_active;
      @(negedge clk);
      char_en = 1'b1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      ctl_hsync = 1'b1; ctl_vsync = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 mon_hsync in reset", 32'(mon_hsync), 32'd0);
      check("R10 mon_vsync in reset", 32'(mon_vsync), 32'd0);
      ctl_hsync = 1'b0; ctl_vsync = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_color(input logic h, input logic v, input logic b,
                          input logic [CW-1:0] p, input logic [CW-1:0] bc);
      logic [CW-1:0] exp;
      @(negedge clk);
      char_en = 1'b0;
      ctl_hsync = h; ctl_vsync = v; ctl_border = b; pix_color = p; border_color = bc;
      #1;
      if (h || v) begin
         exp = '0;
         check("R1 black during sync", 32'(out_color), 32'(exp));
      end else if (b) begin
         check("R2 border colour", 32'(out_color), 32'(bc));
      end else begin
         check("R3 pixel colour", 32'(out_color), 32'(p));
      end
      check("R9 sync_active", 32'(sync_active), 32'(h | v));
      check("R8 vsync_status", 32'(vsync_status), 32'(v));
   endtask

   task automatic t_hline(input int width);
      string tag;
      bit exp;
      tag = (width >= 6) ? "R4 monitor hsync window" : "R5 monitor hsync cut";
      pix_color = 6'h15; border_color = 6'h2a;
      for (int c = 0; c < 64; c++) begin
         char_step((c >= 46) && (c < 46 + width), 1'b0, 1'b0);
         exp = (c >= 48) && (c < 52) && (c < 46 + width);
         check(tag, 32'(s_mh), 32'(exp));
         if (c == 49 && width == 14)
            check("R1 black in hsync", 32'(s_col), 32'd0);
      end
      char_step(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_vframe(input int lines);
      string tag;
      bit exp;
      tag = (lines >= 4) ? "R6 monitor vsync window" : "R7 monitor vsync cut";
      char_step(1'b0, 1'b0, 1'b0);
      char_step(1'b0, 1'b1, 1'b1);
      check(tag, 32'(s_mv), 32'd0);
      check("R8 status follows vsync", 32'(s_stat), 32'd1);
      check("R1 black in vsync with border", 32'(s_col), 32'd0);
      for (int k = 1; k <= lines; k++) begin
         for (int j = 0; j < 2; j++) begin
            char_step(1'b1, 1'b1, 1'b0);
            exp = (k - 1 >= 2) && (k - 1 < 4);
            check(tag, 32'(s_mv), 32'(exp));
         end
         for (int j = 0; j < 3; j++) begin
            char_step(1'b0, 1'b1, 1'b0);
            exp = (k >= 2) && (k < 4);
            check(tag, 32'(s_mv), 32'(exp));
            check("R9 sync_active in vsync", 32'(s_sa), 32'd1);
         end
      end
      char_step(1'b0, 1'b0, 1'b0);
      check(tag, 32'(s_mv), 32'd0);
      check("R8 status drops", 32'(s_stat), 32'd0);
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_color(1'b0, 1'b0, 1'b0, 6'h11, 6'h22);
      t_color(1'b0, 1'b0, 1'b0, 6'h3f, 6'h00);
      t_color(1'b0, 1'b0, 1'b1, 6'h11, 6'h22);
      t_color(1'b0, 1'b0, 1'b1, 6'h05, 6'h3c);
      t_color(1'b1, 1'b0, 1'b1, 6'h11, 6'h22);
      t_color(1'b0, 1'b1, 1'b0, 6'h3f, 6'h22);
      t_color(1'b1, 1'b1, 1'b1, 6'h3f, 6'h3f);
      t_color(1'b0, 1'b0, 1'b0, 6'h2b, 6'h3f);
      t_hline(14);
      t_hline(4);
      t_hline(2);
      t_hline(6);
      t_vframe(6);
      t_vframe(3);
      t_vframe(1);
      finish_run();
   end
endmodule